// File: doc/BRIEF.md
# Completion and Message Interrupt Controller

This block keeps a small interrupt status word and an interrupt enable word behind a 32-bit register port. Two internal event strobes, one for finished work and one for unsolicited messages, each set their own status bit. Software acknowledges by writing ones to the status word (write-one-to-clear) and programs the enable word by writing a whole new value.

Whenever the status or the enable word changes, the block re-evaluates whether any enabled status bit is set. With message-signalled delivery turned off, that condition is held on a level interrupt line. With it turned on, the level line stays low and the block emits a one-cycle notification pulse for each update that leaves the condition true. A status write made while completed work is still queued also raises a one-cycle retry request, so the completion path gets another chance to post its results.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the status word and the enable word to zero; irq_level, msi_pulse and retry_req are low while reset is held and after it is released.
- R2: A write to byte offset 0x0 clears every status bit whose data bit is 1 and leaves every other status bit unchanged; reading offset 0x0 returns the status word, whose bits 31..2 always read 0.
- R3: A write to byte offset 0x4 replaces all 32 bits of the enable word; reading offset 0x4 returns the last value written.
- R4: evt_cmpl high at a clock edge sets status bit 0 and evt_msg high sets status bit 1; when an event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R5: With msi_en low, irq_level is high exactly when the bitwise AND of status and enable is nonzero, from the edge at which either word changes, and msi_pulse stays low.
- R6: With msi_en high, irq_level stays low and msi_pulse is high for exactly the one cycle after an edge at which an event, a status write or an enable write occurred and the updated AND of status and enable is nonzero; otherwise msi_pulse is low.
- R7: retry_req is high for exactly the one cycle after an edge at which a status write occurred while cmpl_pending was high; enable writes and status writes without pending work never raise it.
- R8: Reads of any offset other than 0x0 and 0x4 (including offsets that are not a multiple of 4) return 0xFFFFFFFF, and writes to them change neither word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, full 32-bit word |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data, bit 0 is the least significant bit |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_cmpl | input | 1 | Completion event strobe |
| evt_msg | input | 1 | Message event strobe |
| cmpl_pending | input | 1 | Completed work is still waiting to be posted |
| msi_en | input | 1 | Selects message-signalled delivery |
| irq_level | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle notification pulse |
| retry_req | output | 1 | One-cycle request to re-run completion posting |

## Verification
The assertions assume that event strobes, write strobes and cmpl_pending are held low while reset is asserted, so that the first look into the past after reset sees quiet inputs; the bench drives every input to zero before releasing reset and only when asserting it mid-run. They also assume inputs are stable around the rising edge, which the stimulus guarantees by changing inputs one time unit after each edge and sampling outputs there. The sweep covers every combination of delivery mode, low enable bits and event pattern, each from a cleared status word, and directed cases cover the event-versus-clear collision, the retry conditions and stray offsets.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned CMPL_BIT = 0;
  localparam int unsigned MSG_BIT  = 1;
  localparam logic [REG_W-1:0] UNMAPPED_VAL = '1;

  // Write-one-to-clear update with set priority
  function automatic logic [NUM_SRC-1:0] w1c_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] clr,
    input logic [NUM_SRC-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  // Interrupt condition: any enabled source pending
  function automatic logic irq_cond(
    input logic [NUM_SRC-1:0] st,
    input logic [REG_W-1:0]   en
  );
    return |(st & en[NUM_SRC-1:0]);
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned EN_OFS   = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  stat_word,
  input  logic [REG_W-1:0]  en_word,
  output logic              st_wr,
  output logic              en_wr,
  output logic [REG_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);

  logic aligned;
  logic st_hit;
  logic en_hit;

  assign aligned = (addr[1:0] == 2'b00);
  assign st_hit  = aligned && (addr == ST_A);
  assign en_hit  = aligned && (addr == EN_A);
  assign st_wr   = wr_en && st_hit;
  assign en_wr   = wr_en && en_hit;

  always_comb begin
    rdata = UNMAPPED_VAL;
    if (st_hit) begin
      rdata = stat_word;
    end else if (en_hit) begin
      rdata = en_word;
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] st_q,
  output logic [NUM_SRC-1:0] st_nxt
);

  assign st_nxt = clr_en ? w1c_next(st_q, clr_vec, set_vec) : (st_q | set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_nxt;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
    // R4
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> st_q[i]);
    // R2
    w1c_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_vec[i] && !set_vec[i]) |=> !st_q[i]);
    // R2
    untouched_bit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(clr_en && clr_vec[i]) && !set_vec[i]) |=> $stable(st_q[i]));
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] en_nxt
);

  assign en_nxt = wr ? wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_nxt;
    end
  end

  // R3
  en_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q == $past(wdata)));

endmodule

// File: rtl/irq_notify.sv
module irq_notify
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_en,
  input  logic               upd,
  input  logic               st_wr,
  input  logic               cmpl_pending,
  input  logic [NUM_SRC-1:0] st_q,
  input  logic [REG_W-1:0]   en_q,
  input  logic [NUM_SRC-1:0] st_nxt,
  input  logic [REG_W-1:0]   en_nxt,
  output logic               irq_level,
  output logic               msi_pulse,
  output logic               retry_req
);

  logic cond_now;
  logic cond_nxt;
  logic pulse_q;
  logic retry_q;

  assign cond_now = irq_cond(st_q, en_q);
  assign cond_nxt = irq_cond(st_nxt, en_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      pulse_q <= msi_en && upd && cond_nxt;
      retry_q <= st_wr && cmpl_pending;
    end
  end

  assign irq_level = !msi_en && cond_now;
  assign msi_pulse = pulse_q;
  assign retry_req = retry_q;

  // R6
  msi_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !irq_level);
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(upd && msi_en));
  // R7
  retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> $past(st_wr && cmpl_pending));
  // R7
  retry_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && cmpl_pending) |=> retry_req);

endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned EN_OFS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_cmpl,
  input  logic              evt_msg,
  input  logic              cmpl_pending,
  input  logic              msi_en,
  output logic              irq_level,
  output logic              msi_pulse,
  output logic              retry_req
);

  localparam int unsigned PAD_W = REG_W - NUM_SRC;

  logic               st_wr;
  logic               en_wr;
  logic               upd;
  logic               map_miss;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] st_q;
  logic [NUM_SRC-1:0] st_nxt;
  logic [REG_W-1:0]   en_q;
  logic [REG_W-1:0]   en_nxt;
  logic [REG_W-1:0]   stat_word;

  assign set_vec[CMPL_BIT] = evt_cmpl;
  assign set_vec[MSG_BIT]  = evt_msg;
  assign stat_word = {{PAD_W{1'b0}}, st_q};
  assign upd       = st_wr || en_wr || evt_cmpl || evt_msg;
  assign map_miss  = reg_wr && !st_wr && !en_wr;

  irq_reg_decode #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .EN_OFS  (EN_OFS)
  ) u_decode (
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .stat_word(stat_word),
    .en_word  (en_q),
    .st_wr    (st_wr),
    .en_wr    (en_wr),
    .rdata    (reg_rdata)
  );

  irq_status_bank u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_en (st_wr),
    .clr_vec(reg_wdata[NUM_SRC-1:0]),
    .st_q   (st_q),
    .st_nxt (st_nxt)
  );

  irq_enable_reg u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_wr),
    .wdata (reg_wdata),
    .en_q  (en_q),
    .en_nxt(en_nxt)
  );

  irq_notify u_notify (
    .clk         (clk),
    .rst_n       (rst_n),
    .msi_en      (msi_en),
    .upd         (upd),
    .st_wr       (st_wr),
    .cmpl_pending(cmpl_pending),
    .st_q        (st_q),
    .en_q        (en_q),
    .st_nxt      (st_nxt),
    .en_nxt      (en_nxt),
    .irq_level   (irq_level),
    .msi_pulse   (msi_pulse),
    .retry_req   (retry_req)
  );

  // R8
  stray_write_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_miss |=> $stable(en_q));
  // R5
  level_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq_level);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq_level && !msi_pulse && !retry_req));

endmodule

// File: tb/cmpl_irq_ctrl_bench.sv
module cmpl_irq_ctrl_bench;

  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_ST = 4'h0;
  localparam logic [AW-1:0] A_EN = 4'h4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          evt_cmpl = 1'b0;
  logic          evt_msg = 1'b0;
  logic          cmpl_pending = 1'b0;
  logic          msi_en = 1'b0;
  logic          irq_level;
  logic          msi_pulse;
  logic          retry_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_st;
  logic [31:0] m_en;

  always #5 clk = ~clk;

  cmpl_irq_ctrl #(.ADDR_W(AW)) u_cmpl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_cmpl(evt_cmpl),
    .evt_msg(evt_msg), .cmpl_pending(cmpl_pending), .msi_en(msi_en),
    .irq_level(irq_level), .msi_pulse(msi_pulse), .retry_req(retry_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d, input logic pend);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    cmpl_pending = pend;
    tick();
    reg_wr = 1'b0;
    cmpl_pending = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic m_cond();
    return |(m_st[1:0] & m_en[1:0]);
  endfunction

  initial begin
    logic [31:0] rv;
    logic        c;
    m_st = '0;
    m_en = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs while reset is held
    chk("R1", "irq_level in reset", {31'b0, irq_level}, 32'h0);
    chk("R1", "msi_pulse in reset", {31'b0, msi_pulse}, 32'h0);
    chk("R1", "retry_req in reset", {31'b0, retry_req}, 32'h0);
    rst_n = 1'b1;
    tick();
    rd_reg(A_ST, rv); chk("R1", "status after reset", rv, 32'h0);
    rd_reg(A_EN, rv); chk("R1", "enable after reset", rv, 32'h0);

    // Sweep: delivery mode x enable low bits x event pattern
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 4; e++) begin
        for (int s = 0; s < 4; s++) begin
          msi_en = m[0];
          wr_reg(A_ST, 32'hFFFF_FFFF, 1'b0);
          m_st = '0;
          wr_reg(A_EN, 32'hA5A5_0000 | e, 1'b0);
          m_en = 32'hA5A5_0000 | e;
          chk("R6", "pulse after enable write, nothing pending", {31'b0, msi_pulse}, 32'h0);
          evt_cmpl = s[0];
          evt_msg  = s[1];
          tick();
          evt_cmpl = 1'b0;
          evt_msg  = 1'b0;
          m_st = m_st | s;
          c = m_cond();
          chk("R5", "irq_level after events", {31'b0, irq_level}, {31'b0, !m[0] && c});
          chk("R6", "msi_pulse after events", {31'b0, msi_pulse}, {31'b0, m[0] && c});
          rd_reg(A_ST, rv); chk("R4", "status after events", rv, m_st);
          tick();
          chk("R6", "msi_pulse one cycle only", {31'b0, msi_pulse}, 32'h0);
          wr_reg(A_ST, 32'h0000_0001, 1'b0);
          m_st = m_st & ~32'h1;
          c = m_cond();
          chk("R5", "irq_level after clearing bit 0", {31'b0, irq_level}, {31'b0, !m[0] && c});
          chk("R6", "msi_pulse after status write", {31'b0, msi_pulse}, {31'b0, m[0] && c});
          rd_reg(A_ST, rv); chk("R2", "status after clearing bit 0", rv, m_st);
          rd_reg(A_EN, rv); chk("R3", "enable readback", rv, m_en);
        end
      end
    end

    // R5 enable write re-evaluates the level immediately
    msi_en = 1'b0;
    wr_reg(A_EN, 32'h0, 1'b0);
    evt_msg = 1'b1; tick(); evt_msg = 1'b0;
    chk("R5", "level with message bit masked", {31'b0, irq_level}, 32'h0);
    wr_reg(A_EN, 32'h2, 1'b0);
    chk("R5", "level after unmasking message bit", {31'b0, irq_level}, 32'h1);

    // R4 event and clear on the same bit at the same edge
    wr_reg(A_ST, 32'hFFFF_FFFF, 1'b0);
    evt_cmpl = 1'b1; tick(); evt_cmpl = 1'b0;
    evt_cmpl = 1'b1;
    wr_reg(A_ST, 32'h1, 1'b0);
    evt_cmpl = 1'b0;
    rd_reg(A_ST, rv); chk("R4", "set wins over clear", rv, 32'h1);

    // R7 retry conditions
    wr_reg(A_ST, 32'h0, 1'b1);
    chk("R7", "retry after status write with pending", {31'b0, retry_req}, 32'h1);
    tick();
    chk("R7", "retry lasts one cycle", {31'b0, retry_req}, 32'h0);
    wr_reg(A_ST, 32'h0, 1'b0);
    chk("R7", "no retry without pending", {31'b0, retry_req}, 32'h0);
    wr_reg(A_EN, 32'h3, 1'b1);
    chk("R7", "no retry on enable write", {31'b0, retry_req}, 32'h0);

    // R8 stray offsets
    rd_reg(4'h8, rv); chk("R8", "read offset 0x8", rv, 32'hFFFF_FFFF);
    rd_reg(4'hC, rv); chk("R8", "read offset 0xC", rv, 32'hFFFF_FFFF);
    rd_reg(4'h1, rv); chk("R8", "read offset 0x1", rv, 32'hFFFF_FFFF);
    rd_reg(4'h6, rv); chk("R8", "read offset 0x6", rv, 32'hFFFF_FFFF);
    evt_cmpl = 1'b1; evt_msg = 1'b1; tick(); evt_cmpl = 1'b0; evt_msg = 1'b0;
    wr_reg(4'h8, 32'hFFFF_FFFF, 1'b0);
    wr_reg(4'h1, 32'hFFFF_FFFF, 1'b0);
    wr_reg(4'h5, 32'h0, 1'b0);
    wr_reg(4'hC, 32'h0, 1'b0);
    rd_reg(A_ST, rv); chk("R8", "status after stray writes", rv, 32'h3);
    rd_reg(A_EN, rv); chk("R8", "enable after stray writes", rv, 32'h3);

    // R1 reset in the middle of operation
    rst_n = 1'b0;
    #2;
    chk("R1", "irq_level during mid-run reset", {31'b0, irq_level}, 32'h0);
    tick();
    rst_n = 1'b1;
    tick();
    rd_reg(A_ST, rv); chk("R1", "status after mid-run reset", rv, 32'h0);
    rd_reg(A_EN, rv); chk("R1", "enable after mid-run reset", rv, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule